// File: doc/BRIEF.md
# Pixel-Rate Offset and Gain Stage

This block takes a stream of already-corrected image samples and, for each sample, first removes a per-pixel offset and then scales the difference by a per-pixel gain. Both correction words are presented on their own parallel input buses in the same clock cycle as the sample they belong to, and all three are captured together on the rising clock edge. The corrected pixel leaves the block a fixed number of clock cycles later, together with a valid flag that has travelled down the pipeline beside it.

Three configuration inputs shape the arithmetic. One picks how many bits of the offset bus are used, one picks how many bits of the gain bus are used (and so the number of gain steps), and a three-bit selector picks the gain reached by the all-ones gain code. The configuration is sampled on the same edge as the pixel, so the settings can be changed between any two pixels while the stream keeps running.

There are no states in this block beyond the pipeline registers: every stage either holds a valid pixel or a bubble. Reset is the only event that changes this, and it turns every stage into a bubble.

Top module: `gain_offset_stage`

## Requirements
- R1: A sample and its offset and gain words presented before rising edge k appear on `pix_out` with `pix_valid` high directly after rising edge k+8, that is nine edges after capture including the capture edge.
- R2: `ofs_wsel` values 0, 1, 2 and 3 make the offset word 8, 9, 10 and 10 bits wide, taken from the low bits of `ofs_bus`; higher bus bits have no effect on the result.
- R3: The offset word, read as an unsigned count of LSBs, is subtracted from the sample; a negative difference is clamped to 0 before the gain is applied.
- R4: `gain_wsel` values 0, 1, 2 and 3 make the gain word N = 10, 11, 12 and 12 bits wide, taken from the low bits of `gain_bus`; higher bus bits have no effect on the result.
- R5: A gain word of zero gives a gain of exactly one: the output equals the clamped difference.
- R6: The output is the clamped difference d times 1 + code·(G−1)/2^N, rounded to the nearest LSB with halves rounded up, where G is 1.5, 2, 3, 4, 5, 6, 7, 8 for `gmax_sel` 0 to 7.
- R7: A scaled result above 4095 is saturated to 4095.
- R8: The width and full-scale settings in force at a pixel's capture edge are the ones applied to that pixel, even when they change on every edge.
- R9: `pix_valid` follows `in_valid` with the same delay as the data; while reset is asserted and on the edge after it, `pix_valid` and `pix_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, all capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the cycle's sample as a real pixel |
| in_sample | input | 12 | Corrected input sample, unsigned |
| ofs_bus | input | 10 | Per-pixel offset word, straight binary |
| gain_bus | input | 12 | Per-pixel gain word, straight binary |
| ofs_wsel | input | 2 | Offset word width select |
| gain_wsel | input | 2 | Gain word width select |
| gmax_sel | input | 3 | Full-scale gain select |
| pix_valid | output | 1 | Output pixel valid |
| pix_out | output | 12 | Corrected, scaled pixel |

## Verification
Two functions can meet on a single pixel: a reconfiguration of the bus widths and a capture whose bus words carry set bits above the newly selected width. The bench provokes this by changing `ofs_wsel`, `gain_wsel` and `gmax_sel` on every cycle while driving full-width random words, and also by pairing a large offset (clamp to zero) with the largest gain, so the clamp and the scaling act on the same pixel. Each output is judged against a behavioural model that applies the masking, clamp, rounding and saturation of the settings driven with that very pixel, delayed by nine edges in a queue.

// File: rtl/gos_pkg.sv
package gos_pkg;

    // Twice the step from unity to full-scale gain: 2*(G-1) for G = 1.5 .. 8.
    function automatic logic [3:0] gmax_k(input logic [2:0] sel);
        logic [3:0] k;
        unique case (sel)
            3'd0: k = 4'd1;
            3'd1: k = 4'd2;
            3'd2: k = 4'd4;
            3'd3: k = 4'd6;
            3'd4: k = 4'd8;
            3'd5: k = 4'd10;
            3'd6: k = 4'd12;
            default: k = 4'd14;
        endcase
        return k;
    endfunction

    // Width select clipped to its three legal steps.
    function automatic logic [1:0] clip_sel(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/gos_capture.sv
module gos_capture
    import gos_pkg::*;
#(
    parameter int DW = 12,
    parameter int OW = 10,
    parameter int GW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic [OW-1:0] ofs_bus,
    input  logic [GW-1:0] gain_bus,
    input  logic [1:0]    ofs_wsel,
    input  logic [1:0]    gain_wsel,
    input  logic [2:0]    gmax_sel,
    output logic          c_valid,
    output logic [DW-1:0] c_sample,
    output logic [OW-1:0] c_ofs,
    output logic [GW-1:0] c_code,
    output logic [3:0]    c_nbits,
    output logic [3:0]    c_k
);
    localparam int OW_MIN = OW - 2;
    localparam int GW_MIN = GW - 2;

    logic [3:0]    obits, gbits;
    logic [OW-1:0] omask;
    logic [GW-1:0] gmask;

    always_comb begin
        obits = 4'(OW_MIN) + {2'b00, clip_sel(ofs_wsel)};
        gbits = 4'(GW_MIN) + {2'b00, clip_sel(gain_wsel)};
        omask = ~({OW{1'b1}} << obits);
        gmask = ~({GW{1'b1}} << gbits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_valid  <= 1'b0;
            c_sample <= '0;
            c_ofs    <= '0;
            c_code   <= '0;
            c_nbits  <= '0;
            c_k      <= '0;
        end else begin
            c_valid  <= in_valid;
            c_sample <= in_sample;
            c_ofs    <= ofs_bus & omask;
            c_code   <= gain_bus & gmask;
            c_nbits  <= gbits;
            c_k      <= gmax_k(gmax_sel);
        end
    end

endmodule

// File: rtl/gos_offset.sv
module gos_offset #(
    parameter int DW = 12,
    parameter int OW = 10,
    parameter int GW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          c_valid,
    input  logic [DW-1:0] c_sample,
    input  logic [OW-1:0] c_ofs,
    input  logic [GW-1:0] c_code,
    input  logic [3:0]    c_nbits,
    input  logic [3:0]    c_k,
    output logic          o_valid,
    output logic [DW-1:0] o_diff,
    output logic [GW-1:0] o_code,
    output logic [3:0]    o_nbits,
    output logic [3:0]    o_k
);
    logic [DW:0] wide_diff;

    always_comb begin
        wide_diff = {1'b0, c_sample} - {{(DW + 1 - OW){1'b0}}, c_ofs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_diff  <= '0;
            o_code  <= '0;
            o_nbits <= '0;
            o_k     <= '0;
        end else begin
            o_valid <= c_valid;
            o_diff  <= wide_diff[DW] ? '0 : wide_diff[DW-1:0];
            o_code  <= c_code;
            o_nbits <= c_nbits;
            o_k     <= c_k;
        end
    end

    // R3: subtraction never raises a sample
    assert_diff_not_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid |=> (o_valid && o_diff <= $past(c_sample)));

    // R3: an offset at or above the sample yields zero
    assert_clamp_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && {{(DW + 1 - OW){1'b0}}, c_ofs} >= {1'b0, c_sample}) |=> (o_diff == '0));

endmodule

// File: rtl/gos_gain.sv
module gos_gain #(
    parameter int DW = 12,
    parameter int GW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_diff,
    input  logic [GW-1:0] in_code,
    input  logic [3:0]    in_nbits,
    input  logic [3:0]    in_k,
    output logic          y_valid,
    output logic [DW-1:0] y
);
    localparam int PW    = DW + GW;
    localparam int SUM_W = PW + 6;

    logic             a_v;
    logic [DW-1:0]    a_diff;
    logic [PW-1:0]    a_p;
    logic [3:0]       a_n, a_k;
    logic             b_v;
    logic [SUM_W-1:0] b_sum;
    logic [3:0]       b_n;
    logic [SUM_W-1:0] sum_next, shifted;
    logic [DW-1:0]    y_next;

    always_comb begin
        sum_next = ({{(SUM_W - DW){1'b0}}, a_diff} << (5'(a_n) + 5'd1))
                 + SUM_W'(a_p) * SUM_W'(a_k)
                 + (SUM_W'(1) << a_n);
        shifted  = b_sum >> (5'(b_n) + 5'd1);
        y_next   = (|shifted[SUM_W-1:DW]) ? {DW{1'b1}} : shifted[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_v     <= 1'b0;
            a_diff  <= '0;
            a_p     <= '0;
            a_n     <= '0;
            a_k     <= '0;
            b_v     <= 1'b0;
            b_sum   <= '0;
            b_n     <= '0;
            y_valid <= 1'b0;
            y       <= '0;
        end else begin
            a_v     <= in_valid;
            a_diff  <= in_diff;
            a_p     <= PW'(in_diff) * PW'(in_code);
            a_n     <= in_nbits;
            a_k     <= in_k;
            b_v     <= a_v;
            b_sum   <= sum_next;
            b_n     <= a_n;
            y_valid <= b_v;
            y       <= y_next;
        end
    end

    // R5: a zero gain code passes the difference through unchanged
    assert_unity_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code == '0) |-> ##3 (y_valid && y == $past(in_diff, 3)));

    // R6: gain is never below one
    assert_gain_not_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 (y >= $past(in_diff, 3)));

endmodule

// File: rtl/gos_delay.sv
module gos_delay #(
    parameter int DW    = 12,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_valid,
    input  logic [DW-1:0] d_data,
    output logic          q_valid,
    output logic [DW-1:0] q_data
);
    generate
        if (DEPTH == 0) begin : g_none
            assign q_valid = d_valid;
            assign q_data  = d_data;
        end else begin : g_pipe
            logic [DEPTH-1:0]         vp;
            logic [DEPTH-1:0][DW-1:0] dp;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vp <= '0;
                    dp <= '0;
                end else begin
                    for (int i = DEPTH - 1; i > 0; i--) begin
                        vp[i] <= vp[i-1];
                        dp[i] <= dp[i-1];
                    end
                    vp[0] <= d_valid;
                    dp[0] <= d_data;
                end
            end

            assign q_valid = vp[DEPTH-1];
            assign q_data  = dp[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/gain_offset_stage.sv
module gain_offset_stage #(
    parameter int DW      = 12,
    parameter int OW      = 10,
    parameter int GW      = 12,
    parameter int LATENCY = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic [OW-1:0] ofs_bus,
    input  logic [GW-1:0] gain_bus,
    input  logic [1:0]    ofs_wsel,
    input  logic [1:0]    gain_wsel,
    input  logic [2:0]    gmax_sel,
    output logic          pix_valid,
    output logic [DW-1:0] pix_out
);
    localparam int CORE_STAGES = 5;
    localparam int PAD = (LATENCY > CORE_STAGES) ? LATENCY - CORE_STAGES : 0;

    logic          c_valid, o_valid, g_valid;
    logic [DW-1:0] c_sample, o_diff, g_y;
    logic [OW-1:0] c_ofs;
    logic [GW-1:0] c_code, o_code;
    logic [3:0]    c_nbits, c_k, o_nbits, o_k;

    gos_capture #(.DW(DW), .OW(OW), .GW(GW)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ofs_bus(ofs_bus), .gain_bus(gain_bus), .ofs_wsel(ofs_wsel),
        .gain_wsel(gain_wsel), .gmax_sel(gmax_sel),
        .c_valid(c_valid), .c_sample(c_sample), .c_ofs(c_ofs), .c_code(c_code),
        .c_nbits(c_nbits), .c_k(c_k)
    );

    gos_offset #(.DW(DW), .OW(OW), .GW(GW)) u_ofs (
        .clk(clk), .rst_n(rst_n), .c_valid(c_valid), .c_sample(c_sample),
        .c_ofs(c_ofs), .c_code(c_code), .c_nbits(c_nbits), .c_k(c_k),
        .o_valid(o_valid), .o_diff(o_diff), .o_code(o_code),
        .o_nbits(o_nbits), .o_k(o_k)
    );

    gos_gain #(.DW(DW), .GW(GW)) u_gain (
        .clk(clk), .rst_n(rst_n), .in_valid(o_valid), .in_diff(o_diff),
        .in_code(o_code), .in_nbits(o_nbits), .in_k(o_k),
        .y_valid(g_valid), .y(g_y)
    );

    gos_delay #(.DW(DW), .DEPTH(PAD)) u_dly (
        .clk(clk), .rst_n(rst_n), .d_valid(g_valid), .d_data(g_y),
        .q_valid(pix_valid), .q_data(pix_out)
    );

    // R9: reset leaves no valid pixel on the output
    assert_reset_flush_R9: assert property (@(posedge clk)
        !rst_n |=> (!pix_valid && pix_out == '0));

endmodule

// File: tb/sim_gain_offset_stage.sv
module sim_gain_offset_stage;
    localparam int LAT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [9:0]  ofs_bus = '0;
    logic [11:0] gain_bus = '0;
    logic [1:0]  ofs_wsel = '0;
    logic [1:0]  gain_wsel = '0;
    logic [2:0]  gmax_sel = '0;
    logic        pix_valid;
    logic [11:0] pix_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int    qv[$];
    int    qd[$];
    string qt[$];

    always #5 clk = ~clk;

    gain_offset_stage u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ofs_bus(ofs_bus), .gain_bus(gain_bus), .ofs_wsel(ofs_wsel),
        .gain_wsel(gain_wsel), .gmax_sel(gmax_sel),
        .pix_valid(pix_valid), .pix_out(pix_out)
    );

    // Behavioural model of R2..R7 on the settings driven with the pixel.
    function automatic int model(int s, int o, int g, int ow, int gw, int gm);
        int obits = 8 + ((ow == 3) ? 2 : ow);
        int n = 10 + ((gw == 3) ? 2 : gw);
        int d = s - (o & ((1 << obits) - 1));
        int c = g & ((1 << n) - 1);
        int k;
        longint y;
        case (gm)
            0: k = 1;  1: k = 2;  2: k = 4;  3: k = 6;
            4: k = 8;  5: k = 10; 6: k = 12; default: k = 14;
        endcase
        if (d < 0) d = 0;
        y = ((longint'(d) << (n + 1)) + longint'(d) * c * k + (longint'(1) << n)) >>> (n + 1);
        if (y > 4095) y = 4095;
        return int'(y);
    endfunction

    task automatic check(bit ok, string tag, int av, int ad, int ev, int ed);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got valid=%0d data=%0d expected valid=%0d data=%0d",
                     tag, av, ad, ev, ed);
        end
    endtask

    task automatic step(bit v, int s, int o, int g, int ow, int gw, int gm, string tag);
        @(negedge clk);
        if (qv.size() == LAT) begin
            int ev = qv.pop_front();
            int ed = qd.pop_front();
            string et = qt.pop_front();
            if (ev != 0)
                check(pix_valid && pix_out == ed, et, pix_valid, pix_out, 1, ed);
            else
                check(!pix_valid, {et, " R9"}, pix_valid, pix_out, 0, 0);
        end else begin
            check(!pix_valid, "R9 pipeline fill", pix_valid, pix_out, 0, 0);
        end
        in_valid  = v;
        in_sample = 12'(s);
        ofs_bus   = 10'(o);
        gain_bus  = 12'(g);
        ofs_wsel  = 2'(ow);
        gain_wsel = 2'(gw);
        gmax_sel  = 3'(gm);
        qv.push_back(v ? 1 : 0);
        qd.push_back(model(s, o, g, ow, gw, gm));
        qt.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        qv.delete();
        qd.delete();
        qt.delete();
        @(negedge clk);
        check(!pix_valid && pix_out == 0, "R9 reset state", pix_valid, pix_out, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, 0, 0, 0, "R9 drain");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got valid=%0d data=%0d expected valid=0 data=0",
                     pix_valid, pix_out);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(!pix_valid && pix_out == 0, "R9 reset state", pix_valid, pix_out, 0, 0);
        rst_n = 1'b1;

        // R1 R5: single pixel, unity gain, latency exactly nine edges
        step(1, 1234, 0, 0, 2, 2, 7, "R1 latency unity");
        drain();
        for (int i = 0; i < 40; i++)
            step(1, int'($urandom_range(4095)), 0, 0, i % 4, (i / 4) % 4, i % 8, "R5 unity gain");

        // R3: offsets around and above the sample, clamping to zero
        for (int i = 0; i < 40; i++)
            step(1, int'($urandom_range(1100)), int'($urandom_range(1023)), 0, 2, 2, 0, "R3 offset clamp");

        // R2: upper offset bits set beyond the chosen width
        for (int i = 0; i < 48; i++)
            step(1, int'($urandom_range(4095)), int'($urandom_range(1023)) | 10'h300,
                 int'($urandom_range(4095)), i % 3, 2, i % 8, "R2 offset width mask");

        // R4: upper gain bits set beyond the chosen width
        for (int i = 0; i < 48; i++)
            step(1, int'($urandom_range(2000)), 0, int'($urandom_range(4095)) | 12'hC00,
                 0, i % 4, i % 8, "R4 gain width mask");

        // R6: every full-scale setting, random codes, and all-ones codes
        for (int gm = 0; gm < 8; gm++) begin
            for (int i = 0; i < 12; i++)
                step(1, int'($urandom_range(511)), int'($urandom_range(63)),
                     int'($urandom_range(4095)), 0, i % 3, gm, "R6 gain curve");
            step(1, 300, 0, 4095, 0, 2, gm, "R6 full-scale code");
        end

        // R7: large samples with large gain saturate
        for (int i = 0; i < 24; i++)
            step(1, 3000 + int'($urandom_range(1095)), 0, 3500 + int'($urandom_range(595)),
                 0, 2, 4 + (i % 4), "R7 saturation");

        // R8: settings change every cycle, combined with clamp and top gain
        for (int i = 0; i < 120; i++)
            step(1, int'($urandom_range(4095)), int'($urandom_range(1023)),
                 int'($urandom_range(4095)), int'($urandom_range(3)),
                 int'($urandom_range(3)), int'($urandom_range(7)), "R8 per-pixel config");

        // R9: valid gaps travel with the data
        for (int i = 0; i < 60; i++)
            step(($urandom_range(1) == 1), int'($urandom_range(4095)), int'($urandom_range(255)),
                 int'($urandom_range(4095)), 0, 0, 3, "R9 valid gaps");

        // R9: reset in the middle of a full pipeline
        do_reset();
        for (int i = 0; i < 20; i++)
            step(1, int'($urandom_range(4095)), 0, int'($urandom_range(1023)), 0, 0, 1, "R1 after reset");
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule